// File: doc/BRIEF.md
# Byte-Port SPI Master

This block is an SPI master for a single slave, reached from a host through an 8-bit parallel port. The host first stores a configuration byte that chooses the SCLK rate, the active level of chip select and the SCLK idle level. It then loads a 16-bit data word one byte at a time and pulses a start strobe. The block exchanges the word full duplex, most significant bit first, in clock phase 1. SCLK leads each bit and the slave samples on the trailing edge. The bits returned on MISO replace the word in the same register.

While the exchange runs, `busy` stays high. Once `busy` falls, the host reads the received word back through the output port, one byte at a time. The write-enable and start inputs pass through flip-flops before use. SCLK, CS and MOSI are driven straight from flip-flops.

Top module: `spi_byte_master`

## Requirements
- R1: After a synchronous reset, the configuration is zero. `busy`=0, `csOut`=1 (active-low, idle), `sclk`=0, `mosi`=0, and the data register reads 0x0000.
- R2: A write with `cfgSel`=1 stores the configuration byte. Bits [3:0] hold the divide select, bit 4 is the CS active level (1 = active high) and bit 5 is CPOL. Bits [7:6] are ignored. Writing 0x20 gives active-low CS, CPOL=1 and divide select 0.
- R3: With divide select n, each SCLK half period lasts 2^n system clocks, so the SCLK rate is the system clock divided by 2^(n+1).
- R4: A write with `cfgSel`=0 loads `dataIn` into data bits [15:8] when `byteSel`=1, and into bits [7:0] when `byteSel`=0. The write takes effect two clock edges after `wrEn` rises.
- R5: A rising edge on `startReq` while idle raises `busy`. Exactly 16 SCLK cycles (32 edges) follow, and then `busy` falls.
- R6: `csOut` sits at the programmed active level in every cycle in which `busy` is high, and at the opposite level otherwise.
- R7: While idle, `sclk` sits at the CPOL level.
- R8: MOSI changes only on leading SCLK edges and sends bit 15 first. MISO is sampled on trailing edges. After a transfer, the data register holds the 16 bits received, first bit in bit 15.
- R9: Writes (data or configuration) and start strobes that arrive while `busy` is high have no effect.
- R10: While `busy` is low, `dataOut` shows data bits [15:8] when `byteSel`=1 and bits [7:0] when `byteSel`=0. While `busy` is high it reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Host write byte |
| dataOut | output | 8 | Host read byte |
| wrEn | input | 1 | Host write enable (synchronised inside) |
| byteSel | input | 1 | Selects the upper (1) or lower (0) data byte |
| cfgSel | input | 1 | Directs a write to the configuration register |
| startReq | input | 1 | Start strobe, acts on its rising edge (synchronised inside) |
| busy | output | 1 | Transfer in progress |
| csOut | output | 1 | Registered chip select to the slave |
| sclk | output | 1 | Registered serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
The assertions rely on a few conditions at the host port. `dataIn`, `cfgSel` and `byteSel` must stay steady from the clock where `wrEn` rises until the write has landed two edges later. MISO must settle before the trailing-edge clock. The stimulus meets both conditions. It changes every input on the falling system clock edge, holds the write fields for three cycles around each one-cycle `wrEn` pulse, and has the slave model update MISO only when it sees a leading edge. The one exception is deliberate: writes and a start strobe are injected in the middle of a transfer to show that they are dropped.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_SHIFT = 2'd1,
    XF_TAIL  = 2'd2
  } xferState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic loadHi;
    logic loadLo;
    logic launch;    // leading SCLK edge: drive next MOSI bit
    logic sample;    // trailing SCLK edge: capture MISO
    logic active;    // transfer in progress this cycle
    logic busyNext;  // transfer in progress next cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/spi_bm_ctrl.sv
module spi_bm_ctrl
  import spi_bm_pkg::*;
#(
  parameter int FRAME_W   = 16,
  parameter int DIV_SEL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wrEn,
  input  logic                 startReq,
  input  logic                 cfgSel,
  input  logic                 byteSel,
  input  logic [DIV_SEL_W-1:0] divSel,
  output logic                 busy,
  output ctrlStrobes_t         st
);
  localparam int CNT_W = 2 ** DIV_SEL_W;
  localparam int BIT_W = $clog2(FRAME_W);

  logic wrSync, startSync, startPrev;
  xferState_t state, stateNext;
  logic [CNT_W-1:0] divCnt, halfLast;
  logic [BIT_W-1:0] bitCnt;
  logic phaseTrail;
  logic tick, startEdge, idle, lastBit;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrSync    <= 1'b0;
      startSync <= 1'b0;
      startPrev <= 1'b0;
    end else begin
      wrSync    <= wrEn;
      startSync <= startReq;
      startPrev <= startSync;
    end
  end

  assign idle      = (state == XF_IDLE);
  assign startEdge = startSync & ~startPrev;
  assign halfLast  = (CNT_W'(1) << divSel) - CNT_W'(1);
  assign tick      = !idle && (divCnt == halfLast);
  assign lastBit   = (bitCnt == BIT_W'(FRAME_W - 1));

  always_comb begin
    stateNext = state;
    unique case (state)
      XF_IDLE:  if (startEdge) stateNext = XF_SHIFT;
      XF_SHIFT: if (tick && phaseTrail && lastBit) stateNext = XF_TAIL;
      XF_TAIL:  if (tick) stateNext = XF_IDLE;
      default:  stateNext = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= XF_IDLE;
      divCnt     <= '0;
      bitCnt     <= '0;
      phaseTrail <= 1'b0;
    end else begin
      state  <= stateNext;
      divCnt <= (idle || tick) ? '0 : divCnt + CNT_W'(1);
      if (idle) begin
        bitCnt     <= '0;
        phaseTrail <= 1'b0;
      end else if (tick && state == XF_SHIFT) begin
        phaseTrail <= ~phaseTrail;
        if (phaseTrail && !lastBit) bitCnt <= bitCnt + BIT_W'(1);
      end
    end
  end

  always_comb begin
    st          = '0;
    st.loadCfg  = idle && wrSync && cfgSel;
    st.loadHi   = idle && wrSync && !cfgSel && byteSel;
    st.loadLo   = idle && wrSync && !cfgSel && !byteSel;
    st.launch   = tick && (state == XF_SHIFT) && !phaseTrail;
    st.sample   = tick && (state == XF_SHIFT) && phaseTrail;
    st.active   = !idle;
    st.busyNext = (stateNext != XF_IDLE);
  end

  assign busy = !idle;

  // R4: at most one register action per cycle
  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st.launch, st.sample, st.loadCfg, st.loadHi, st.loadLo}));

  // R3: divider never runs past the selected half period
  p_div_bound_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> divCnt <= halfLast);

  // R5: busy only ends after the final bit was exchanged
  p_end_after_last_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> lastBit && !phaseTrail);

endmodule

// File: rtl/spi_bm_dpath.sv
module spi_bm_dpath
  import spi_bm_pkg::*;
#(
  parameter int HOST_W    = 8,
  parameter int DIV_SEL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrlStrobes_t         st,
  input  logic [HOST_W-1:0]    dataIn,
  input  logic                 byteSel,
  input  logic                 miso,
  output logic [HOST_W-1:0]    dataOut,
  output logic [DIV_SEL_W-1:0] divSel,
  output logic                 csOut,
  output logic                 sclk,
  output logic                 mosi
);
  localparam int FRAME_W = 2 * HOST_W;
  localparam int CFG_W   = DIV_SEL_W + 2;
  localparam int CS_BIT  = DIV_SEL_W;
  localparam int POL_BIT = DIV_SEL_W + 1;

  logic [CFG_W-1:0]   cfgQ, cfgD;
  logic [FRAME_W-1:0] shiftReg;

  assign cfgD   = st.loadCfg ? dataIn[CFG_W-1:0] : cfgQ;
  assign divSel = cfgQ[DIV_SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgQ     <= '0;
      shiftReg <= '0;
      mosi     <= 1'b0;
      sclk     <= 1'b0;
      csOut    <= 1'b1;
    end else begin
      cfgQ <= cfgD;
      if (st.loadHi) shiftReg[FRAME_W-1:HOST_W] <= dataIn;
      if (st.loadLo) shiftReg[HOST_W-1:0] <= dataIn;
      if (st.sample) shiftReg <= {shiftReg[FRAME_W-2:0], miso};
      if (st.launch) mosi <= shiftReg[FRAME_W-1];
      if (!st.busyNext)   sclk <= cfgD[POL_BIT];
      else if (st.launch) sclk <= ~cfgQ[POL_BIT];
      else if (st.sample) sclk <= cfgQ[POL_BIT];
      csOut <= st.busyNext ? cfgD[CS_BIT] : ~cfgD[CS_BIT];
    end
  end

  always_comb begin
    if (st.active)   dataOut = '0;
    else if (byteSel) dataOut = shiftReg[FRAME_W-1:HOST_W];
    else              dataOut = shiftReg[HOST_W-1:0];
  end

  // R6: chip select held at the active level through a transfer
  p_cs_active_r6: assert property (@(posedge clk) disable iff (rst)
    st.active |-> csOut == cfgQ[CS_BIT]);

  // R7: SCLK parked at CPOL while idle
  p_sclk_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !st.active |-> sclk == cfgQ[POL_BIT]);

  // R8: MOSI moves only on a leading edge
  p_mosi_launch_r8: assert property (@(posedge clk) disable iff (rst)
    !st.launch |=> $stable(mosi));

  // R9: during a transfer only sampling alters the data word
  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st.active && !st.sample) |=> $stable(shiftReg));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int HOST_W    = 8,
  parameter int DIV_SEL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOST_W-1:0] dataIn,
  output logic [HOST_W-1:0] dataOut,
  input  logic              wrEn,
  input  logic              byteSel,
  input  logic              cfgSel,
  input  logic              startReq,
  output logic              busy,
  output logic              csOut,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int FRAME_W = 2 * HOST_W;

  ctrlStrobes_t         st;
  logic [DIV_SEL_W-1:0] divSel;

  spi_bm_ctrl #(.FRAME_W(FRAME_W), .DIV_SEL_W(DIV_SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .startReq(startReq),
    .cfgSel(cfgSel), .byteSel(byteSel), .divSel(divSel),
    .busy(busy), .st(st)
  );

  spi_bm_dpath #(.HOST_W(HOST_W), .DIV_SEL_W(DIV_SEL_W)) u_dpath (
    .clk(clk), .rst(rst), .st(st), .dataIn(dataIn), .byteSel(byteSel),
    .miso(miso), .dataOut(dataOut), .divSel(divSel),
    .csOut(csOut), .sclk(sclk), .mosi(mosi)
  );

endmodule

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;
  // {config byte, word to send, word the slave returns}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h20, 16'h0700, 16'hA55A},
    {8'hD1, 16'h1234, 16'h8001},
    {8'h02, 16'hFFFF, 16'h0000},
    {8'h33, 16'h5AC3, 16'h7E81}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic wrEn = 1'b0, byteSel = 1'b0, cfgSel = 1'b0, startReq = 1'b0;
  logic busy, csOut, sclk, mosi;
  logic miso = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst(rst), .dataIn(dataIn), .dataOut(dataOut), .wrEn(wrEn),
    .byteSel(byteSel), .cfgSel(cfgSel), .startReq(startReq), .busy(busy),
    .csOut(csOut), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic isCfg, input logic hi, input logic [7:0] val);
    @(negedge clk);
    cfgSel = isCfg; byteSel = hi; dataIn = val; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic readWord(output logic [15:0] w);
    @(negedge clk); byteSel = 1'b1; cfgSel = 1'b0;
    #1 w[15:8] = dataOut;
    byteSel = 1'b0;
    #1 w[7:0] = dataOut;
  endtask

  // Runs one transfer with a slave model; optionally injects writes and a
  // start strobe after the given number of SCLK edges.
  task automatic doTransfer(input logic [15:0] slaveWord, input logic cpol,
                            input logic csAct, input int halfExp, input int injectAt,
                            output logic [15:0] gotMosi, output int edges,
                            output int badHalf, output int badCs, output int badOut,
                            output bit sawBusy);
    logic prevSclk;
    int lastEdge, lead, trail;
    bit done;
    edges = 0; badHalf = 0; badCs = 0; badOut = 0; sawBusy = 0;
    lead = 0; trail = 0; lastEdge = 0; gotMosi = '0; done = 0;
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    prevSclk = sclk;
    for (int t = 0; t < 80000 && !done; t++) begin
      @(negedge clk);
      wrEn = 1'b0; startReq = 1'b0;
      if (busy) begin
        sawBusy = 1;
        if (csOut !== csAct) badCs++;
        if (dataOut !== 8'h00) badOut++;
      end else if (sawBusy) begin
        done = 1;
      end
      if (sclk !== prevSclk) begin
        if (edges > 0 && (cyc - lastEdge) != halfExp) badHalf++;
        lastEdge = cyc;
        edges++;
        if (sclk !== cpol) begin
          if (lead < 16) miso = slaveWord[15 - lead];
          lead++;
        end else begin
          if (trail < 16) gotMosi[15 - trail] = mosi;
          trail++;
        end
        if (edges == injectAt) begin
          cfgSel = 1'b1; dataIn = 8'h3F; wrEn = 1'b1; startReq = 1'b1;
        end
        if (edges == injectAt + 4) begin
          cfgSel = 1'b0; byteSel = 1'b1; dataIn = 8'hFF; wrEn = 1'b1;
        end
      end
      prevSclk = sclk;
    end
    wrEn = 1'b0; startReq = 1'b0; cfgSel = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [15:0] w, got;
    int edges, badHalf, badCs, badOut;
    bit sawBusy;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0, "R1 busy", busy, 0);
    chk(csOut === 1'b1, "R1 csOut", csOut, 1);
    chk(sclk === 1'b0, "R1 sclk", sclk, 0);
    chk(mosi === 1'b0, "R1 mosi", mosi, 0);
    readWord(w);
    chk(w === 16'h0000, "R1 data", w, 0);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] cfg;
      logic [15:0] tx, rx;
      cfg = VEC[v][39:32]; tx = VEC[v][31:16]; rx = VEC[v][15:0];
      hostWrite(1'b1, 1'b0, cfg);
      hostWrite(1'b0, 1'b1, tx[15:8]);
      hostWrite(1'b0, 1'b0, tx[7:0]);
      @(negedge clk);
      // R2 / R7: idle levels follow the configuration bits
      chk(csOut === ~cfg[4], "R2 idle cs", csOut, ~cfg[4]);
      chk(sclk === cfg[5], "R7 idle sclk", sclk, cfg[5]);
      readWord(w);
      chk(w === tx, "R4 R10 readback", w, tx);
      doTransfer(rx, cfg[5], cfg[4], 1 << cfg[3:0], -10,
                 got, edges, badHalf, badCs, badOut, sawBusy);
      chk(sawBusy, "R5 busy seen", sawBusy, 1);
      chk(edges == 32, "R5 edge count", edges, 32);
      chk(badHalf == 0, "R3 half period", badHalf, 0);
      chk(badCs == 0, "R6 cs during busy", badCs, 0);
      chk(badOut == 0, "R10 dataOut zero while busy", badOut, 0);
      chk(got === tx, "R8 mosi word", got, tx);
      readWord(w);
      chk(w === rx, "R8 received word", w, rx);
      chk(csOut === ~cfg[4], "R6 cs released", csOut, ~cfg[4]);
      chk(sclk === cfg[5], "R7 sclk parked", sclk, cfg[5]);
    end

    // R2: example byte 0x20 gives active-low CS, CPOL=1, divide by 2
    hostWrite(1'b1, 1'b0, 8'h20);
    hostWrite(1'b0, 1'b1, 8'h0F);
    hostWrite(1'b0, 1'b0, 8'h0F);
    @(negedge clk);
    chk(csOut === 1'b1 && sclk === 1'b1, "R2 cfg 0x20", {csOut, sclk}, 2'b11);
    // R9: injected config write, data write and start while busy
    doTransfer(16'h3C3C, 1'b1, 1'b0, 1, 6, got, edges, badHalf, badCs, badOut, sawBusy);
    chk(edges == 32, "R9 start ignored", edges, 32);
    chk(badCs == 0, "R9 cfg write ignored (cs)", badCs, 0);
    chk(got === 16'h0F0F, "R9 mosi unaffected", got, 16'h0F0F);
    readWord(w);
    chk(w === 16'h3C3C, "R9 data write ignored", w, 16'h3C3C);
    chk(csOut === 1'b1 && sclk === 1'b1, "R9 cfg kept", {csOut, sclk}, 2'b11);
    begin
      int rose = 0;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (busy) rose++;
      end
      chk(rose == 0, "R9 no second transfer", rose, 0);
    end

    // R4: write latency of two edges
    @(negedge clk);
    cfgSel = 1'b0; byteSel = 1'b0; dataIn = 8'h99; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
    chk(dataOut === 8'h3C, "R4 not yet written", dataOut, 8'h3C);
    @(negedge clk);
    chk(dataOut === 8'h99, "R4 written after two edges", dataOut, 8'h99);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule